// File: doc/BRIEF.md
# PHY Management Register File

This block models the management register set of an Ethernet PHY together with the small MAC-side shim that reaches it. The PHY side holds sixteen 16-bit registers with fixed power-on contents, per-register write rules, a self-clearing soft reset in the control register, and status and partner-ability registers that follow a link-state input. The shim side holds a target register (PHY address and register index), a command register, a write-data register, a read-data register and a link-fail flag. Only one PHY address answers.

Software selects a PHY and register by writing the target register. Writing the write-data register performs the PHY write at once. A command word can repeat that write, fetch a register into the read-data register, or arm a scan mode in which link changes refresh the link-fail flag without any read. Every access completes in one clock; serial bit timing on the management wires is not modelled.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, PHY register 0 reads 0x1000, register 1 reads 0x7868, register 2 reads 0x2000, register 3 reads 0x5C90, register 4 reads 0x01E1 and all others read 0x0000, with link down; the read-data output is 0x0000 and the link-fail output is 0.
- R2: PHY registers 1, 2 and 3 ignore writes; every other register with index below 16 stores the written word unchanged.
- R3: A write to register 0 with bit 15 set stores nothing from the word and restores every register to its R1 value, with the current link state then applied as in R4 or R5.
- R4: When the link input rises, register 1 gets bit 2 set and register 5 gets 0x01E1 ORed in.
- R5: When the link input falls, register 1 gets bit 2 cleared and register 5 is ANDed with 0x01FF.
- R6: Shim select 0 writes the target word (register index in bits 12:8, PHY address in bits 4:0); select 2 writes the write-data register and, when the PHY address is 1, writes that word into the targeted PHY register in the same cycle.
- R7: Shim select 1 writes the command word; bit 2 writes the stored write-data word into the targeted register when the PHY address is 1. Writes aimed at any other PHY address change nothing.
- R8: Command bit 1 loads the read-data output, one clock later, with the targeted register's value (0x0000 for index 16 to 31) when the PHY address is 1, or with 0xFFFF otherwise; the read-data output holds its value at all other times.
- R9: Writes to register indices 16 to 31 change no register.
- R10: Command bit 1 sets the link-fail output to the inverse of the link input.
- R11: While the stored command bit 0 (scan) is 1, each link change sets link-fail to the inverse of the new link state; with scan at 0, link changes leave link-fail unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Current link state, 1 = up |
| sh_we_i | input | 1 | Shim register write strobe |
| sh_sel_i | input | 2 | Shim register select: 0 target, 1 command, 2 write-data, 3 none |
| sh_wdata_i | input | 16 | Shim write word |
| rd_data_o | output | 16 | Shim read-data register |
| link_fail_o | output | 1 | Shim link-fail flag |

## Verification
The hardest state to reach from the ports is the partner-ability register after a mix of software writes, link edges and soft resets, since it is only visible through a targeted read and its content depends on the order of those events. The bench fills every register with a distinct word, toggles the link in both directions, issues a soft reset while the link is in a known state, and reads all sixteen registers after each step against a model updated by the same rules. Scan-driven link-fail updates are reached by arming scan with a command word that has the read bit clear, then moving the link with no read in between.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    typedef enum logic [1:0] {
        SEL_TARGET = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_WDATA  = 2'd2,
        SEL_NONE   = 2'd3
    } shim_sel_e;

    // register indices with special behaviour
    localparam int IDX_CTRL    = 0;
    localparam int IDX_STATUS  = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADVERT  = 4;
    localparam int IDX_PARTNER = 5;

    localparam int CTRL_SOFT_RST_BIT = 15;
    localparam int STATUS_LINK_BIT   = 2;

    localparam logic [15:0] ABILITY_SET  = 16'h01E1;
    localparam logic [15:0] PARTNER_KEEP = 16'h01FF;

    // command word bits
    localparam int CMD_SCAN_BIT  = 0;
    localparam int CMD_READ_BIT  = 1;
    localparam int CMD_WRITE_BIT = 2;

    localparam int TGT_REG_LSB = 8;
    localparam int TGT_PHY_LSB = 0;
    localparam int PHY_AW      = 5;

    function automatic logic [15:0] power_on_value(input int idx);
        case (idx)
            IDX_CTRL:   return 16'h1000;
            IDX_STATUS: return 16'h7868;
            IDX_ID_HI:  return 16'h2000;
            IDX_ID_LO:  return 16'h5C90;
            IDX_ADVERT: return ABILITY_SET;
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic logic is_read_only(input int idx);
        return (idx == IDX_STATUS) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

endpackage

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import phy_mgmt_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int REG_W = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    localparam int SEL_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
        logic                       link;
    } bank_st_t;

    function automatic bank_st_t boot_state();
        bank_st_t s;
        for (int i = 0; i < NREG; i++) begin
            s.regs[i] = REG_W'(power_on_value(i));
        end
        s.link = 1'b0;
        return s;
    endfunction

    localparam bank_st_t BOOT = boot_state();

    bank_st_t st_d, st_q;
    logic     in_range;
    logic     soft_rst;
    logic     link_apply;

    assign in_range = (int'(idx) < NREG);

    always_comb begin
        st_d     = st_q;
        soft_rst = 1'b0;
        if (wr_en && in_range) begin
            if (int'(idx) == IDX_CTRL && wr_data[CTRL_SOFT_RST_BIT]) begin
                soft_rst = 1'b1;
                st_d.regs = BOOT.regs;
            end else if (!is_read_only(int'(idx))) begin
                st_d.regs[idx[SEL_W-1:0]] = wr_data;
            end
        end
        st_d.link  = link_up;
        link_apply = soft_rst || (link_up != st_q.link);
        if (link_apply) begin
            if (link_up) begin
                st_d.regs[IDX_STATUS][STATUS_LINK_BIT] = 1'b1;
                st_d.regs[IDX_PARTNER] = st_d.regs[IDX_PARTNER] | REG_W'(ABILITY_SET);
            end else begin
                st_d.regs[IDX_STATUS][STATUS_LINK_BIT] = 1'b0;
                st_d.regs[IDX_PARTNER] = st_d.regs[IDX_PARTNER] & REG_W'(PARTNER_KEEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BOOT;
        else        st_q <= st_d;
    end

    assign rd_data = in_range ? st_q.regs[idx[SEL_W-1:0]] : '0;

endmodule

// File: rtl/phy_mgmt_shim.sv
module phy_mgmt_shim
    import phy_mgmt_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int IDX_W    = 5,
    parameter int PHY_ADDR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] bank_rd_data,
    output logic             bank_wr_en,
    output logic [IDX_W-1:0] bank_idx,
    output logic [REG_W-1:0] bank_wr_data,
    output logic             phy_hit,
    output logic [REG_W-1:0] rd_data,
    output logic             link_fail
);
    typedef struct packed {
        logic [IDX_W-1:0]  reg_idx;
        logic [PHY_AW-1:0] phy;
        logic              scan;
        logic [REG_W-1:0]  wbuf;
        logic [REG_W-1:0]  rbuf;
        logic              fail;
        logic              link;
    } shim_st_t;

    shim_st_t st_d, st_q;

    assign phy_hit  = (st_q.phy == PHY_AW'(PHY_ADDR));
    assign bank_idx = st_q.reg_idx;

    always_comb begin
        st_d         = st_q;
        bank_wr_en   = 1'b0;
        bank_wr_data = st_q.wbuf;
        st_d.link    = link_up;
        if (st_q.scan && (link_up != st_q.link)) begin
            st_d.fail = !link_up;
        end
        if (we) begin
            case (shim_sel_e'(sel))
                SEL_TARGET: begin
                    st_d.reg_idx = wdata[TGT_REG_LSB +: IDX_W];
                    st_d.phy     = wdata[TGT_PHY_LSB +: PHY_AW];
                end
                SEL_CMD: begin
                    st_d.scan = wdata[CMD_SCAN_BIT];
                    if (wdata[CMD_WRITE_BIT] && phy_hit) begin
                        bank_wr_en = 1'b1;
                    end
                    if (wdata[CMD_READ_BIT]) begin
                        st_d.rbuf = phy_hit ? bank_rd_data : '1;
                        st_d.fail = !link_up;
                    end
                end
                SEL_WDATA: begin
                    st_d.wbuf = wdata;
                    if (phy_hit) begin
                        bank_wr_en   = 1'b1;
                        bank_wr_data = wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rbuf;
    assign link_fail = st_q.fail;

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int REG_W    = 16,
    parameter int IDX_W    = 5,
    parameter int PHY_ADDR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up_i,
    input  logic             sh_we_i,
    input  logic [1:0]       sh_sel_i,
    input  logic [REG_W-1:0] sh_wdata_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             link_fail_o
);
    logic             bank_wr_en;
    logic [IDX_W-1:0] bank_idx;
    logic [REG_W-1:0] bank_wr_data;
    logic [REG_W-1:0] bank_rd_data;
    logic             phy_hit;

    phy_mgmt_shim #(
        .REG_W(REG_W), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)
    ) u_shim (
        .clk(clk), .rst_n(rst_n), .link_up(link_up_i),
        .we(sh_we_i), .sel(sh_sel_i), .wdata(sh_wdata_i),
        .bank_rd_data(bank_rd_data), .bank_wr_en(bank_wr_en),
        .bank_idx(bank_idx), .bank_wr_data(bank_wr_data),
        .phy_hit(phy_hit), .rd_data(rd_data_o), .link_fail(link_fail_o)
    );

    phy_reg_bank #(
        .NREG(NREG), .REG_W(REG_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .link_up(link_up_i),
        .wr_en(bank_wr_en), .idx(bank_idx), .wr_data(bank_wr_data),
        .rd_data(bank_rd_data)
    );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_up,
    input logic             we,
    input logic [1:0]       sel,
    input logic             rd_bit,
    input logic [REG_W-1:0] rd_data,
    input logic             link_fail,
    input logic             phy_hit,
    input logic             bank_wr_en
);
    logic rd_cmd;
    assign rd_cmd = we && (sel == 2'd1) && rd_bit;

    // R8
    miss_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !phy_hit) |=> (rd_data == '1));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd |=> $stable(rd_data));

    // R10
    fail_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (link_fail == !$past(link_up)));

    // R7
    write_only_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |-> (phy_hit && we));

    // R11
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && $stable(link_up)) |=> $stable(link_fail));

endmodule

bind phy_mgmt_regfile phy_mgmt_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_up(link_up_i), .we(sh_we_i),
    .sel(sh_sel_i), .rd_bit(sh_wdata_i[1]), .rd_data(rd_data_o),
    .link_fail(link_fail_o), .phy_hit(phy_hit), .bank_wr_en(bank_wr_en)
);

// File: tb/sim_phy_mgmt_regfile.sv
module sim_phy_mgmt_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd3;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        link_fail;

    int checks = 0;
    int errors = 0;
    logic [15:0] m [16];

    always #5 clk = ~clk;

    phy_mgmt_regfile u0 (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .sh_we_i(we),
        .sh_sel_i(sel), .sh_wdata_i(wdata), .rd_data_o(rd_data),
        .link_fail_o(link_fail)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic m_link(input bit up);
        if (up) begin m[1] = m[1] | 16'h0004; m[5] = m[5] | 16'h01E1; end
        else    begin m[1] = m[1] & ~16'h0004; m[5] = m[5] & 16'h01FF; end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m[i] = 16'h0000;
        m[0] = 16'h1000; m[1] = 16'h7868; m[2] = 16'h2000;
        m[3] = 16'h5C90; m[4] = 16'h01E1;
        m_link(link_up);
    endtask

    task automatic m_write(input int idx, input logic [15:0] v);
        if (idx >= 16) return;
        if (idx == 0 && v[15]) m_reset();
        else if (idx < 1 || idx > 3) m[idx] = v;
    endtask

    task automatic sh(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = v;
        @(negedge clk);
        we = 1'b0; sel = 2'd3;
    endtask

    task automatic target(input int phy, input int idx);
        sh(2'd0, {3'b000, 5'(idx), 3'b000, 5'(phy)});
    endtask

    task automatic phy_wr(input int phy, input int idx, input logic [15:0] v);
        target(phy, idx);
        sh(2'd2, v);
        if (phy == 1) m_write(idx, v);
    endtask

    task automatic phy_rd(input int phy, input int idx, input logic [15:0] exp, input string tag);
        target(phy, idx);
        sh(2'd1, 16'h0002);
        chk(rd_data, exp, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 16; i++) phy_rd(1, i, m[i], tag);
    endtask

    task automatic set_link(input bit up);
        @(negedge clk);
        link_up = up;
        m_link(up);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data, 16'h0000, "R1 rd_data after reset");
        chk({15'd0, link_fail}, 16'h0000, "R1 link_fail after reset");
        read_all("R1 power-on contents");
        chk({15'd0, link_fail}, 16'h0001, "R10 read with link down");

        // R2 R6: fill through the write-data register
        for (int i = 0; i < 16; i++) phy_wr(1, i, 16'h0A50 + 16'(i) * 16'h0101);
        read_all("R2 sweep A");
        for (int i = 0; i < 16; i++) phy_wr(1, i, 16'h7000 | 16'(i << 4) | 16'(15 - i));
        read_all("R2 sweep B");

        // R4 and R5 link edges
        phy_wr(1, 5, 16'hFE00);
        set_link(1'b1);
        read_all("R4 link up");
        chk({15'd0, link_fail}, 16'h0000, "R10 read with link up");
        set_link(1'b0);
        read_all("R5 link down");

        // R3 soft reset with link up
        set_link(1'b1);
        phy_wr(1, 6, 16'h1234);
        phy_wr(1, 0, 16'h8ABC);
        read_all("R3 soft reset");

        // R8 R7: other PHY address
        phy_rd(3, 4, 16'hFFFF, "R8 miss address");
        phy_wr(3, 7, 16'hBEEF);
        phy_wr(0, 8, 16'hCAFE);
        read_all("R7 miss write ignored");

        // R9 out-of-range index
        phy_wr(1, 20, 16'h5555);
        phy_wr(1, 31, 16'hAAAA);
        read_all("R9 high index ignored");
        phy_rd(1, 17, 16'h0000, "R8 high index reads zero");

        // R7 command write of buffered word
        phy_wr(2, 9, 16'h6789);
        target(1, 9);
        sh(2'd1, 16'h0004);
        m_write(9, 16'h6789);
        phy_rd(1, 9, m[9], "R7 command write");
        chk(rd_data, 16'h6789, "R7 command write value");

        // R8 hold: no read, read-data unchanged
        phy_wr(1, 10, 16'h4321);
        chk(rd_data, 16'h6789, "R8 hold without read");

        // R11 scan behaviour
        sh(2'd1, 16'h0001);
        chk({15'd0, link_fail}, 16'h0000, "R11 scan armed, link up");
        set_link(1'b0);
        chk({15'd0, link_fail}, 16'h0001, "R11 scan link down");
        set_link(1'b1);
        chk({15'd0, link_fail}, 16'h0000, "R11 scan link up");
        sh(2'd1, 16'h0000);
        set_link(1'b0);
        chk({15'd0, link_fail}, 16'h0000, "R11 no scan, held");
        read_all("R5 final contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule